// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block tracks ownership of a circular ring of receive descriptors that a packet receiver and a software consumer share. Software hands descriptors to hardware by writing the tail index. Hardware fills descriptors starting at the head index. When the receiver reports a completed frame with its length and result flags, the block splits the frame into buffer-sized pieces. It places one piece in each owned slot. For every slot it emits a length write-back and then a status/error write-back, and it advances the head after each slot.

The block drives two events. A low-descriptor event tells software that the number of descriptors still owned by hardware has fallen below a programmed fraction of the ring. An overrun event reports a frame, or the rest of a frame, that found no descriptor. Moving the payload and computing checksums happen elsewhere. The block only carries the checksum and error results into the status and error bytes.

Top module: `rxdesc_ring_mgr`

## Requirements
- R1: After reset the head and tail indices are 0, `busy` is low, and no write-back strobe or event is active.
- R2: A tail write loads `tail_wdata` into `tail_idx` one clock later. Hardware then owns (tail − head) mod DEPTH slots, starting at the head. Equal indices mean hardware owns no slot.
- R3: A frame of at most BUF_BYTES (256) bytes takes one slot, the slot at the current head. The length write-back carries the frame length. The status byte has bit 0 (done) and bit 1 (end of frame) set. The frame flags go to status bit 3 (VLAN tag present), bit 5 (TCP checksum checked) and bit 6 (IP checksum checked). Error byte: bit 0 = frm_err[0] (CRC), bit 2 = frm_err[1] (framing), bit 5 = frm_err[2] (TCP checksum), bit 6 = frm_err[3] (IP checksum), bit 7 = frm_err[4] (data error). All other status and error bits are 0.
- R4: For each slot the length write-back strobe is active for exactly one cycle. The status write-back for the same slot follows in the next cycle. The two strobes are never active together.
- R5: A frame longer than BUF_BYTES fills consecutive slots. Each slot except the last gets length 256, status 0x01 (done without end of frame) and error byte 0x00. The last slot gets the remaining length and the status and errors of R3.
- R6: The head index advances by one after each status write-back and wraps from DEPTH−1 to 0.
- R7: A frame that arrives while hardware owns no slot produces no write-back. It leaves the head unchanged and pulses `ovr_evt` for one cycle.
- R8: If a multi-slot frame uses up the owned slots, the slots written so far keep status 0x01. The rest of the frame is discarded, `ovr_evt` pulses once, and the head stops at the tail.
- R9: `thr_sel` values 0, 1, 2 and 3 set the low level to DEPTH/2, DEPTH/4, DEPTH/8 and DEPTH/8. `low_evt` pulses for one cycle when the owned count goes from at or above the level to below it. It does not pulse again until the count has risen back to the level.
- R10: A `frm_done` strobe that arrives while `busy` is high is ignored. It causes no extra write-back and does not move the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thr_sel | input | 2 | Low-descriptor level select |
| tail_we | input | 1 | Tail register write strobe |
| tail_wdata | input | IDX_W | New tail index |
| frm_done | input | 1 | Frame-complete strobe |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_vlan | input | 1 | Frame carried a VLAN tag |
| frm_l4_chk | input | 1 | TCP checksum was checked |
| frm_l3_chk | input | 1 | IP checksum was checked |
| frm_err | input | 5 | Error flags {data, IP, TCP, framing, CRC} |
| busy | output | 1 | Frame write-back in progress |
| head_idx | output | IDX_W | Next slot hardware fills |
| tail_idx | output | IDX_W | Current tail index |
| wr_len_en | output | 1 | Length write-back strobe |
| wr_stat_en | output | 1 | Status/error write-back strobe |
| wr_slot | output | IDX_W | Slot being written |
| wr_len | output | LEN_W | Length for the slot |
| wr_status | output | 8 | Status byte for the slot |
| wr_errors | output | 8 | Error byte for the slot |
| low_evt | output | 1 | Low-descriptor event pulse |
| ovr_evt | output | 1 | Overrun event pulse |

## Verification
The assertions assume that software only ever moves the tail forward. The tail never passes the slots that hardware owns, so the head never runs into a tail that has just been pulled back. The tail is never loaded with an index of DEPTH or more. The stimulus keeps within this because each tail write adds at most the number of free slots modulo the ring size. Frames are sent only while `busy` is low, except for the single strobe that deliberately lands while busy to test R10. The frame length never exceeds what LEN_W can hold.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LEN  = 2'd1,
    FS_STAT = 2'd2
  } fill_st_e;

  // status byte bit positions (decoded by the consumer)
  localparam int ST_DD  = 0;
  localparam int ST_EOP = 1;
  localparam int ST_VP  = 3;
  localparam int ST_L4  = 5;
  localparam int ST_L3  = 6;

  // error byte bit positions
  localparam int ER_CRC = 0;
  localparam int ER_FRM = 2;
  localparam int ER_L4  = 5;
  localparam int ER_L3  = 6;
  localparam int ER_DAT = 7;

  typedef struct packed {
    logic       vlan;
    logic       l4_chk;
    logic       l3_chk;
    logic [4:0] err;   // {data, ip, tcp, framing, crc}
  } frm_info_t;

  function automatic logic [7:0] mk_status(input logic eop, input frm_info_t f);
    logic [7:0] s;
    s         = '0;
    s[ST_DD]  = 1'b1;
    s[ST_EOP] = eop;
    s[ST_VP]  = eop & f.vlan;
    s[ST_L4]  = eop & f.l4_chk;
    s[ST_L3]  = eop & f.l3_chk;
    return s;
  endfunction

  function automatic logic [7:0] mk_errors(input logic eop, input frm_info_t f);
    logic [7:0] e;
    e         = '0;
    e[ER_CRC] = eop & f.err[0];
    e[ER_FRM] = eop & f.err[1];
    e[ER_L4]  = eop & f.err[2];
    e[ER_L3]  = eop & f.err[3];
    e[ER_DAT] = eop & f.err[4];
    return e;
  endfunction

  function automatic int thr_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      default: return depth / 8;
    endcase
  endfunction

endpackage

// File: rtl/rxr_rst_sync.sv
module rxr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tail_we,
  input  logic [IDX_W-1:0] tail_wdata,
  input  logic             head_inc,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] avail
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W:0]   DEPTH_W  = (IDX_W+1)'(DEPTH);

  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [IDX_W:0]   diff;

  // next state
  always_comb begin
    head_d = head_q;
    if (head_inc) head_d = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
    tail_d = tail_q;
    if (tail_we) tail_d = tail_wdata;
  end

  // owned-slot count, modulo ring depth
  always_comb begin
    diff = {1'b0, tail_q} - {1'b0, head_q};
    if (tail_q >= head_q) avail = diff[IDX_W-1:0];
    else                  avail = IDX_W'(diff + DEPTH_W);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (head_inc) head_q <= head_d;
      if (tail_we)  tail_q <= tail_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;

endmodule

// File: rtl/rxr_thresh.sv
module rxr_thresh #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [IDX_W-1:0] avail,
  output logic             low_evt
);

  import rxr_pkg::*;

  logic [IDX_W:0] level;
  logic           low_now;
  logic           low_q;

  always_comb begin
    level   = (IDX_W+1)'(thr_level(sel, DEPTH));
    low_now = ({1'b0, avail} < level);
  end

  // reset as "already low" so that the empty ring after reset raises nothing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b1;
    else        low_q <= low_now;
  end

  assign low_evt = low_now & ~low_q;

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_done,
  input  logic [LEN_W-1:0]    frm_len,
  input  rxr_pkg::frm_info_t  frm_info,
  input  logic [IDX_W-1:0]    head,
  input  logic [IDX_W-1:0]    avail,
  output logic                busy,
  output logic                head_inc,
  output logic                wr_len_en,
  output logic                wr_stat_en,
  output logic [IDX_W-1:0]    wr_slot,
  output logic [LEN_W-1:0]    wr_len,
  output logic [7:0]          wr_status,
  output logic [7:0]          wr_errors,
  output logic                ovr_evt
);

  import rxr_pkg::*;

  localparam logic [LEN_W-1:0] BUF_L    = LEN_W'(BUF_BYTES);
  localparam logic [IDX_W-1:0] ONE_SLOT = IDX_W'(1);

  fill_st_e         st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  frm_info_t        info_q;
  logic             rem_ld, info_ld;
  logic             ovr_q, ovr_d;
  logic             last_chunk;

  assign last_chunk = (rem_q <= BUF_L);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    rem_ld   = 1'b0;
    info_ld  = 1'b0;
    ovr_d    = 1'b0;
    head_inc = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (frm_done) begin
          if (avail == '0) begin
            ovr_d = 1'b1;
          end else begin
            st_d    = FS_LEN;
            rem_d   = frm_len;
            rem_ld  = 1'b1;
            info_ld = 1'b1;
          end
        end
      end
      FS_LEN: begin
        st_d = FS_STAT;
      end
      FS_STAT: begin
        head_inc = 1'b1;
        if (last_chunk) begin
          st_d = FS_IDLE;
        end else begin
          rem_d  = rem_q - BUF_L;
          rem_ld = 1'b1;
          if (avail == ONE_SLOT) begin
            st_d  = FS_IDLE;
            ovr_d = 1'b1;
          end else begin
            st_d = FS_LEN;
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      rem_q  <= '0;
      info_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovr_q <= ovr_d;
      if (rem_ld)  rem_q  <= rem_d;
      if (info_ld) info_q <= frm_info;
    end
  end

  // write-back outputs: length first, then status for the same slot
  always_comb begin
    wr_len_en  = (st_q == FS_LEN);
    wr_stat_en = (st_q == FS_STAT);
    wr_slot    = head;
    wr_len     = last_chunk ? rem_q : BUF_L;
    wr_status  = wr_stat_en ? mk_status(last_chunk, info_q) : 8'h00;
    wr_errors  = wr_stat_en ? mk_errors(last_chunk, info_q) : 8'h00;
  end

  assign busy    = (st_q != FS_IDLE);
  assign ovr_evt = ovr_q;

endmodule

// File: rtl/rxdesc_ring_mgr.sv
module rxdesc_ring_mgr #(
  parameter int DEPTH     = 16,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 256,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       thr_sel,
  input  logic             tail_we,
  input  logic [IDX_W-1:0] tail_wdata,
  input  logic             frm_done,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_vlan,
  input  logic             frm_l4_chk,
  input  logic             frm_l3_chk,
  input  logic [4:0]       frm_err,
  output logic             busy,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             wr_len_en,
  output logic             wr_stat_en,
  output logic [IDX_W-1:0] wr_slot,
  output logic [LEN_W-1:0] wr_len,
  output logic [7:0]       wr_status,
  output logic [7:0]       wr_errors,
  output logic             low_evt,
  output logic             ovr_evt
);

  import rxr_pkg::*;

  logic             rst_sn;
  logic             head_inc;
  logic [IDX_W-1:0] avail;
  frm_info_t        info;

  assign info = '{vlan: frm_vlan, l4_chk: frm_l4_chk, l3_chk: frm_l3_chk, err: frm_err};

  rxr_rst_sync i_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rxr_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_ptr (
    .clk        (clk),
    .rst_n      (rst_sn),
    .tail_we    (tail_we),
    .tail_wdata (tail_wdata),
    .head_inc   (head_inc),
    .head       (head_idx),
    .tail       (tail_idx),
    .avail      (avail)
  );

  rxr_thresh #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_thr (
    .clk     (clk),
    .rst_n   (rst_sn),
    .sel     (thr_sel),
    .avail   (avail),
    .low_evt (low_evt)
  );

  rxr_fill #(.IDX_W(IDX_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) i_fill (
    .clk        (clk),
    .rst_n      (rst_sn),
    .frm_done   (frm_done),
    .frm_len    (frm_len),
    .frm_info   (info),
    .head       (head_idx),
    .avail      (avail),
    .busy       (busy),
    .head_inc   (head_inc),
    .wr_len_en  (wr_len_en),
    .wr_stat_en (wr_stat_en),
    .wr_slot    (wr_slot),
    .wr_len     (wr_len),
    .wr_status  (wr_status),
    .wr_errors  (wr_errors),
    .ovr_evt    (ovr_evt)
  );

endmodule

// File: rtl/rxdesc_ring_mgr_chk.sv
module rxdesc_ring_mgr_chk #(
  parameter int DEPTH     = 16,
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 256
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             tail_we,
  input logic [IDX_W-1:0] tail_wdata,
  input logic [IDX_W-1:0] head_idx,
  input logic [IDX_W-1:0] tail_idx,
  input logic             wr_len_en,
  input logic             wr_stat_en,
  input logic [IDX_W-1:0] wr_slot,
  input logic [LEN_W-1:0] wr_len,
  input logic [7:0]       wr_status,
  input logic [7:0]       wr_errors,
  input logic             low_evt
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  // R2: tail register loads the written value
  a_r2_tail_load: assert property (@(posedge clk) disable iff (!rst_sn)
    tail_we |=> (tail_idx == $past(tail_wdata)));

  // R3: a slot's length never exceeds one buffer
  a_r3_len_fits: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_len_en |-> (wr_len <= LEN_W'(BUF_BYTES)));

  // R3: every status write-back marks the slot done
  a_r3_done_bit: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stat_en |-> wr_status[0]);

  // R4: status follows the length write of the same slot
  a_r4_stat_after_len: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stat_en |-> ($past(wr_len_en) && ($past(wr_slot) == wr_slot)));

  // R4: the two strobes never coincide
  a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_sn)
    !(wr_len_en && wr_stat_en));

  // R5: a continued slot carries done only
  a_r5_cont_clean: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_stat_en && !wr_status[1]) |-> (wr_status == 8'h01 && wr_errors == 8'h00));

  // R6: head steps by one and wraps
  a_r6_head_step: assert property (@(posedge clk) disable iff (!rst_sn)
    (head_idx != $past(head_idx)) |->
      (head_idx == (($past(head_idx) == LAST_IDX) ? '0 : IDX_W'($past(head_idx) + 1'b1))));

  // R7: no write into a slot hardware does not own
  a_r7_owned_only: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_len_en |-> (head_idx != tail_idx));

  // R9: low event is a single-cycle pulse
  a_r9_low_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    low_evt |=> !low_evt);

endmodule

bind rxdesc_ring_mgr rxdesc_ring_mgr_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)
) i_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .tail_we    (tail_we),
  .tail_wdata (tail_wdata),
  .head_idx   (head_idx),
  .tail_idx   (tail_idx),
  .wr_len_en  (wr_len_en),
  .wr_stat_en (wr_stat_en),
  .wr_slot    (wr_slot),
  .wr_len     (wr_len),
  .wr_status  (wr_status),
  .wr_errors  (wr_errors),
  .low_evt    (low_evt)
);

// File: tb/test_rxdesc_ring_mgr.sv
`timescale 1ns/1ps
module test_rxdesc_ring_mgr;

  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int LEN_W = 11;
  localparam int BUFB  = 256;

  logic             clk;
  logic             rst_n;
  logic [1:0]       thr_sel;
  logic             tail_we;
  logic [IDX_W-1:0] tail_wdata;
  logic             frm_done;
  logic [LEN_W-1:0] frm_len;
  logic             frm_vlan, frm_l4_chk, frm_l3_chk;
  logic [4:0]       frm_err;
  logic             busy;
  logic [IDX_W-1:0] head_idx, tail_idx, wr_slot;
  logic             wr_len_en, wr_stat_en;
  logic [LEN_W-1:0] wr_len;
  logic [7:0]       wr_status, wr_errors;
  logic             low_evt, ovr_evt;

  int total = 0;
  int bad   = 0;
  int exp_head = 0;
  int exp_tail = 0;
  int cur_sel  = 0;

  rxdesc_ring_mgr #(.DEPTH(DEPTH), .LEN_W(LEN_W), .BUF_BYTES(BUFB)) i_rxdesc_ring_mgr (
    .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .tail_we(tail_we), .tail_wdata(tail_wdata),
    .frm_done(frm_done), .frm_len(frm_len), .frm_vlan(frm_vlan), .frm_l4_chk(frm_l4_chk),
    .frm_l3_chk(frm_l3_chk), .frm_err(frm_err), .busy(busy), .head_idx(head_idx),
    .tail_idx(tail_idx), .wr_len_en(wr_len_en), .wr_stat_en(wr_stat_en), .wr_slot(wr_slot),
    .wr_len(wr_len), .wr_status(wr_status), .wr_errors(wr_errors), .low_evt(low_evt),
    .ovr_evt(ovr_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int sel);
    return (sel == 0) ? 8 : (sel == 1) ? 4 : 2;
  endfunction

  task automatic do_reset(input int sel);
    rst_n = 1'b0; tail_we = 1'b0; tail_wdata = '0; frm_done = 1'b0; frm_len = '0;
    frm_vlan = 1'b0; frm_l4_chk = 1'b0; frm_l3_chk = 1'b0; frm_err = '0;
    thr_sel = 2'(sel); cur_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_head = 0; exp_tail = 0;
  endtask

  task automatic tail_write(input int v);
    tail_we = 1'b1; tail_wdata = 4'(v);
    @(negedge clk);
    tail_we = 1'b0;
    chk(tail_idx == 4'(v), "R2 tail load", int'(tail_idx), v);
    exp_tail = v;
    @(negedge clk);
  endtask

  // sends a frame and checks every write-back and event it causes
  task automatic send_frame(input int len, input logic [2:0] fl, input logic [4:0] er,
                            input bit poke);
    int needed, avail, nwr, exp_ovr, exp_low, thr;
    int k, got_ovr, got_low, cyc, clen;
    logic [7:0] est, eer;
    needed  = (len == 0) ? 1 : (len + BUFB - 1) / BUFB;
    avail   = (exp_tail - exp_head) & (DEPTH - 1);
    nwr     = (needed < avail) ? needed : avail;
    exp_ovr = (needed > avail) ? 1 : 0;
    thr     = thr_of(cur_sel);
    exp_low = 0;
    for (int i = 0; i < nwr; i++)
      if ((avail - i) >= thr && (avail - i - 1) < thr) exp_low++;

    frm_done = 1'b1; frm_len = 11'(len);
    frm_vlan = fl[0]; frm_l4_chk = fl[1]; frm_l3_chk = fl[2]; frm_err = er;
    k = 0; got_ovr = 0; got_low = 0; cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (wr_len_en) begin
        clen = (k < needed - 1) ? BUFB : len - BUFB * (needed - 1);
        chk(int'(wr_slot) == ((exp_head + k) & (DEPTH - 1)), "R6 len slot", int'(wr_slot),
            (exp_head + k) & (DEPTH - 1));
        chk(int'(wr_len) == clen, "R5 chunk length", int'(wr_len), clen);
      end
      if (wr_stat_en) begin
        if (k == needed - 1) begin
          est = 8'h03 | {1'b0, fl[2], fl[1], 1'b0, fl[0], 3'b000};
          eer = {er[4], er[3], er[2], 2'b00, er[1], 1'b0, er[0]};
        end else begin
          est = 8'h01; eer = 8'h00;
        end
        chk(wr_status == est, "R3 status byte", int'(wr_status), int'(est));
        chk(wr_errors == eer, "R3 error byte", int'(wr_errors), int'(eer));
        k++;
      end
      if (ovr_evt) got_ovr++;
      if (low_evt) got_low++;
      frm_done = (poke && cyc == 2) ? 1'b1 : 1'b0;
    end while (busy && cyc < 64);
    frm_done = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(!wr_len_en && !busy, "R10 no extra activity", int'(wr_len_en), 0);
      if (ovr_evt) got_ovr++;
      if (low_evt) got_low++;
    end
    chk(k == nwr, "R8 slot count", k, nwr);
    chk(got_ovr == exp_ovr, "R7 overrun pulses", got_ovr, exp_ovr);
    chk(got_low == exp_low, "R9 low pulses", got_low, exp_low);
    exp_head = (exp_head + nwr) & (DEPTH - 1);
    chk(int'(head_idx) == exp_head, "R6 head index", int'(head_idx), exp_head);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(0);
    // R1 reset state
    chk(head_idx == '0, "R1 head", int'(head_idx), 0);
    chk(tail_idx == '0, "R1 tail", int'(tail_idx), 0);
    chk(!busy && !wr_len_en && !wr_stat_en, "R1 idle", int'(busy), 0);
    chk(!low_evt && !ovr_evt, "R1 events", int'(low_evt), 0);

    // sweep every threshold select: fill ring, overrun, refill across wrap
    for (int sel = 0; sel < 4; sel++) begin
      do_reset(sel);
      tail_write(15);
      for (int i = 0; i < 15; i++)
        send_frame(16 + i * 16, 3'(i), 5'(i * 7), 1'b0);
      send_frame(100, 3'b111, 5'h1f, 1'b0);          // R7 empty ring
      tail_write((exp_head + 8) & (DEPTH - 1));      // R6 wrap region
      for (int i = 0; i < 8; i++)
        send_frame(BUFB - i * 31, 3'(7 - i), 5'(31 - i), 1'b0);
    end

    // multi-slot frames, boundaries, ignored strobe, mid-frame exhaustion
    do_reset(0);
    tail_write(15);
    send_frame(256, 3'b101, 5'h05, 1'b0);    // R3 exact buffer
    send_frame(257, 3'b010, 5'h0a, 1'b0);    // R5 one byte over
    send_frame(2047, 3'b111, 5'h10, 1'b1);   // R5 eight slots, R10 strobe while busy
    send_frame(0, 3'b000, 5'h00, 1'b0);      // R3 empty frame
    send_frame(700, 3'b001, 5'h03, 1'b0);    // R5 exactly fills the ring
    tail_write(2);
    send_frame(1000, 3'b110, 5'h1f, 1'b0);   // R8 runs out after three slots

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule